// File: doc/BRIEF.md
# BCD Calendar Counter

This block holds the time of day and the calendar date as seven packed-BCD registers: seconds, minutes, hours, day-of-week, day-of-month, month and a two-digit year covering 2000 to 2099. A free-running sub-second tick feeds an internal prescaler. Every `TICKS_PER_SEC` ticks the prescaler issues one step, and that step is carried through the fields as far as the rollover rules allow. Month lengths and leap Februaries are included.

The hour register carries its own format. Bit 6 selects 12-hour display, and in that mode bit 5 marks PM. The counter rolls over correctly in both formats. Software sets the time through a simple load port that writes one register per cycle. A halt input stops the clock completely, in the way a stopped oscillator would.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour), day-of-week 01, day-of-month 01, month 01 and year 00.
- R2: With loadEn high, loadData is written on the next clock edge to the register chosen by loadAddr. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day-of-month, 5 month and 6 year. Address 7 changes no register.
- R3: The seconds register steps once after every TICKS_PER_SEC subTick cycles. Any load clears the prescaler, so the next step comes a full TICKS_PER_SEC ticks after the load. A load in the same cycle as a due step wins, and no step happens in that cycle.
- R4: Seconds and minutes count 00 to 59 in BCD, with digit carries such as 09 to 10, and wrap to 00 while carrying onward. In 24-hour mode (hour bit 6 clear) the hour counts 00 to 23, and its wrap to 00 advances the date.
- R5: In 12-hour mode (hour bit 6 set, bit 5 = PM, bits 4:0 = 01..12 in BCD):
  - 11 rolls to 12 and toggles PM.
  - 12 rolls to 01 with the same PM flag.
  - 11 PM to 12 AM advances the date.
  - Bit 6 is never changed by counting.
- R6: Day-of-month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R7: February ends at 29 when the year is divisible by 4 (year 00 included) and at 28 otherwise.
- R8: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R9: Day-of-week advances whenever day-of-month does and wraps from 7 to 1.
- R10: While oscHalt is high no register counts and the prescaler holds its value. Loads still take effect. After release, counting resumes from the held prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| subTick | input | 1 | Sub-second tick, one cycle wide per pulse |
| oscHalt | input | 1 | High stops all time keeping |
| loadEn | input | 1 | Register write strobe |
| loadAddr | input | 3 | Register selected for write |
| loadData | input | 8 | BCD value written |
| secOut | output | 8 | Seconds, BCD |
| minOut | output | 8 | Minutes, BCD |
| hourOut | output | 8 | Hours with format and PM flags |
| dowOut | output | 8 | Day of week, 1..7 |
| domOut | output | 8 | Day of month, BCD |
| monOut | output | 8 | Month, BCD |
| yearOut | output | 8 | Year within the century, BCD |

## Verification
The rollover assertions assume that every loaded value is a legal BCD value for its field, in the format selected by the hour register. They also assume that the day-of-month never exceeds the length of the loaded month. The stimulus loads only legal combinations and always places the counter one second before the boundary under test. It loads a complete time before every rollover so that the prescaler starts from zero, and it drives subTick continuously so that each second takes exactly TICKS_PER_SEC cycles.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;

  // register index order is the load address map
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam int HOUR_MODE_BIT = 6;
  localparam int HOUR_PM_BIT   = 5;

  typedef struct packed {
    logic                  secStep;
    logic                  load;
    logic [NUM_FIELDS-1:0] loadSel;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4: even tens need ones 0/4/8, odd tens need ones 2/6
  function automatic logic isLeapBcd(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeapBcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] fieldResetVal(input int idx);
    return (idx == F_DOW || idx == F_DOM || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              oscHalt,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  output calStrobe_t        strb
);

  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0]      preCount;
  logic                  secondDue;
  logic [NUM_FIELDS-1:0] selVec;

  assign secondDue = subTick && !oscHalt && !loadEn && (preCount == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCount <= '0;
    end else if (loadEn) begin
      preCount <= '0;
    end else if (subTick && !oscHalt) begin
      preCount <= (preCount == CNT_LAST) ? '0 : preCount + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sel
    assign selVec[g] = loadEn && (loadAddr == ADDR_W'(g));
  end

  assign strb = '{secStep: secondDue, load: loadEn, loadSel: selVec};

  AST_HALT_HOLDS_PRESCALER: assert property (@(posedge clk) disable iff (!rstN)
    oscHalt && !loadEn |=> preCount == $past(preCount)); // R10

  if (TICKS_PER_SEC > 1) begin : g_gapChk
    AST_NO_STEP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      loadEn |=> !secondDue); // R3
  end

endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
  import bcd_cal_pkg::*;
(
  input  logic [FIELD_W-1:0] hourQ,
  output logic [FIELD_W-1:0] hourNext,
  output logic               dayCarry
);

  logic       mode12;
  logic       pm;
  logic [4:0] h12;
  logic [5:0] h24;
  logic [7:0] inc12;
  logic [7:0] inc24;

  always_comb begin
    mode12   = hourQ[HOUR_MODE_BIT];
    pm       = hourQ[HOUR_PM_BIT];
    h12      = hourQ[4:0];
    h24      = hourQ[5:0];
    inc12    = bcdInc({3'b000, h12});
    inc24    = bcdInc({2'b00, h24});
    hourNext = hourQ;
    dayCarry = 1'b0;
    if (mode12) begin
      if (h12 == 5'h11) begin
        hourNext = {2'b01, ~pm, 5'h12};
        dayCarry = pm;
      end else if (h12 == 5'h12) begin
        hourNext = {2'b01, pm, 5'h01};
      end else begin
        hourNext = {2'b01, pm, inc12[4:0]};
      end
    end else begin
      if (h24 == 6'h23) begin
        hourNext = 8'h00;
        dayCarry = 1'b1;
      end else begin
        hourNext = {2'b00, inc24[5:0]};
      end
    end
  end

endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
  import bcd_cal_pkg::*;
(
  input  logic [FIELD_W-1:0] domQ,
  input  logic [FIELD_W-1:0] monQ,
  input  logic [FIELD_W-1:0] yearQ,
  output logic [FIELD_W-1:0] domNext,
  output logic [FIELD_W-1:0] monNext,
  output logic [FIELD_W-1:0] yearNext,
  output logic               monthEnd,
  output logic               lastMonth
);

  logic [7:0] lastDay;

  always_comb begin
    lastDay   = monthLast(monQ, yearQ);
    monthEnd  = (domQ == lastDay);
    lastMonth = (monQ == 8'h12);
    domNext   = monthEnd  ? 8'h01 : bcdInc(domQ);
    monNext   = lastMonth ? 8'h01 : bcdInc(monQ);
    yearNext  = (yearQ == 8'h99) ? 8'h00 : bcdInc(yearQ);
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import bcd_cal_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  calStrobe_t                           strb,
  input  logic [FIELD_W-1:0]                   loadData,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   fieldsQ
);

  logic [NUM_FIELDS-1:0]              fieldStep;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fieldNext;
  logic [FIELD_W-1:0]                 hourNext;
  logic [FIELD_W-1:0]                 domNext;
  logic [FIELD_W-1:0]                 monNext;
  logic [FIELD_W-1:0]                 yearNext;
  logic                               dayCarry;
  logic                               monthEnd;
  logic                               lastMonth;
  logic                               dayStep;

  cal_hour_unit u_hour (
    .hourQ    (fieldsQ[F_HOUR]),
    .hourNext (hourNext),
    .dayCarry (dayCarry)
  );

  cal_date_unit u_date (
    .domQ      (fieldsQ[F_DOM]),
    .monQ      (fieldsQ[F_MON]),
    .yearQ     (fieldsQ[F_YEAR]),
    .domNext   (domNext),
    .monNext   (monNext),
    .yearNext  (yearNext),
    .monthEnd  (monthEnd),
    .lastMonth (lastMonth)
  );

  // carry chain, seconds upward
  always_comb begin
    fieldStep[F_SEC]  = strb.secStep;
    fieldStep[F_MIN]  = fieldStep[F_SEC] && (fieldsQ[F_SEC] == 8'h59);
    fieldStep[F_HOUR] = fieldStep[F_MIN] && (fieldsQ[F_MIN] == 8'h59);
    dayStep           = fieldStep[F_HOUR] && dayCarry;
    fieldStep[F_DOW]  = dayStep;
    fieldStep[F_DOM]  = dayStep;
    fieldStep[F_MON]  = dayStep && monthEnd;
    fieldStep[F_YEAR] = fieldStep[F_MON] && lastMonth;
  end

  always_comb begin
    fieldNext[F_SEC]  = (fieldsQ[F_SEC] == 8'h59) ? 8'h00 : bcdInc(fieldsQ[F_SEC]);
    fieldNext[F_MIN]  = (fieldsQ[F_MIN] == 8'h59) ? 8'h00 : bcdInc(fieldsQ[F_MIN]);
    fieldNext[F_HOUR] = hourNext;
    fieldNext[F_DOW]  = (fieldsQ[F_DOW] == 8'h07) ? 8'h01 : fieldsQ[F_DOW] + 8'h01;
    fieldNext[F_DOM]  = domNext;
    fieldNext[F_MON]  = monNext;
    fieldNext[F_YEAR] = yearNext;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic [FIELD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= fieldResetVal(i);
      end else if (strb.load && strb.loadSel[i]) begin
        q <= loadData;
      end else if (fieldStep[i]) begin
        q <= fieldNext[i];
      end
    end
    assign fieldsQ[i] = q;
  end

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.loadSel[F_MIN] |=> fieldsQ[F_MIN] == $past(loadData)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.secStep && !strb.load && fieldsQ[F_SEC] == 8'h59 |=> fieldsQ[F_SEC] == 8'h00); // R4

  AST_HOUR_MODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> fieldsQ[F_HOUR][HOUR_MODE_BIT] == $past(fieldsQ[F_HOUR][HOUR_MODE_BIT])); // R5

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    dayStep && !strb.load && fieldsQ[F_DOW] == 8'h07 |=> fieldsQ[F_DOW] == 8'h01); // R9

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    fieldStep[F_YEAR] && !strb.load && fieldsQ[F_YEAR] == 8'h99 |=> fieldsQ[F_YEAR] == 8'h00); // R8

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               subTick,
  input  logic               oscHalt,
  input  logic               loadEn,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [FIELD_W-1:0] loadData,
  output logic [FIELD_W-1:0] secOut,
  output logic [FIELD_W-1:0] minOut,
  output logic [FIELD_W-1:0] hourOut,
  output logic [FIELD_W-1:0] dowOut,
  output logic [FIELD_W-1:0] domOut,
  output logic [FIELD_W-1:0] monOut,
  output logic [FIELD_W-1:0] yearOut
);

  calStrobe_t                         strb;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fieldsQ;

  cal_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .subTick  (subTick),
    .oscHalt  (oscHalt),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .strb     (strb)
  );

  cal_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadData (loadData),
    .fieldsQ  (fieldsQ)
  );

  assign secOut  = fieldsQ[F_SEC];
  assign minOut  = fieldsQ[F_MIN];
  assign hourOut = fieldsQ[F_HOUR];
  assign dowOut  = fieldsQ[F_DOW];
  assign domOut  = fieldsQ[F_DOM];
  assign monOut  = fieldsQ[F_MON];
  assign yearOut = fieldsQ[F_YEAR];

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    oscHalt && !loadEn |=> $stable(fieldsQ)); // R10

endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       subTick;
  logic       oscHalt;
  logic       loadEn;
  logic [2:0] loadAddr;
  logic [7:0] loadData;
  logic [7:0] secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut;

  typedef struct {
    string       tag;
    logic [55:0] vals; // {year,mon,dom,dow,hour,min,sec}
  } expItem_t;

  expItem_t expQ[$];
  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TICKS)) u_bcd_calendar (
    .clk(clk), .rstN(rstN), .subTick(subTick), .oscHalt(oscHalt),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dowOut(dowOut),
    .domOut(domOut), .monOut(monOut), .yearOut(yearOut)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      expItem_t item;
      logic [55:0] got;
      wait (expQ.size() != 0);
      item = expQ.pop_front();
      got = {yearOut, monOut, domOut, dowOut, hourOut, minOut, secOut};
      checks++;
      if (got !== item.vals) begin
        failures++;
        $display("FAIL %s: got %h expected %h", item.tag, got, item.vals);
      end
    end
  end

  task automatic expectNow(input string tag, input logic [55:0] v);
    expItem_t item;
    item.tag  = tag;
    item.vals = v;
    expQ.push_back(item);
    #1;
  endtask

  task automatic loadReg(input logic [2:0] a, input logic [7:0] d, input bit withTick);
    loadEn   = 1'b1;
    loadAddr = a;
    loadData = d;
    subTick  = withTick;
    @(negedge clk);
    loadEn  = 1'b0;
    subTick = 1'b0;
  endtask

  task automatic setTime(input logic [55:0] v);
    for (int i = 0; i < 7; i++) loadReg(3'(i), v[i*8 +: 8], 1'b0);
  endtask

  task automatic runTicks(input int n);
    subTick = 1'b1;
    repeat (n) @(negedge clk);
    subTick = 1'b0;
  endtask

  task automatic rollCheck(input string tag, input logic [55:0] startV, input logic [55:0] expV);
    setTime(startV);
    runTicks(TICKS);
    expectNow(tag, expV);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; subTick = 1'b0; oscHalt = 1'b0;
    loadEn = 1'b0; loadAddr = '0; loadData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectNow("R1 reset state", {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});

    setTime({8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h30});
    expectNow("R2 load all fields", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h30});
    loadReg(3'd7, 8'h55, 1'b0);
    expectNow("R2 address 7 ignored", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h30});

    runTicks(TICKS - 1);
    expectNow("R3 no step before full second", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h30});
    runTicks(1);
    expectNow("R3 step after full second", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h31});

    runTicks(TICKS - 1);
    loadReg(3'd0, 8'h10, 1'b1);
    expectNow("R3 load wins over due step", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h10});
    runTicks(TICKS - 1);
    expectNow("R3 prescaler cleared by load", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h10});
    runTicks(1);
    expectNow("R3 step after load", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h11});

    rollCheck("R4 seconds BCD digit carry", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h09},
                                            {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h10});
    rollCheck("R4 minute carry", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h19, 8'h59},
                                 {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h20, 8'h00});
    rollCheck("R4 24h day rollover", {8'h25, 8'h06, 8'h14, 8'h03, 8'h23, 8'h59, 8'h59},
                                     {8'h25, 8'h06, 8'h15, 8'h04, 8'h00, 8'h00, 8'h00});
    rollCheck("R4 24h hour 09 to 10", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h59, 8'h59},
                                      {8'h25, 8'h06, 8'h14, 8'h03, 8'h10, 8'h00, 8'h00});

    rollCheck("R5 11AM to 12PM", {8'h25, 8'h06, 8'h14, 8'h03, 8'h51, 8'h59, 8'h59},
                                 {8'h25, 8'h06, 8'h14, 8'h03, 8'h72, 8'h00, 8'h00});
    rollCheck("R5 12PM to 1PM", {8'h25, 8'h06, 8'h14, 8'h03, 8'h72, 8'h59, 8'h59},
                                {8'h25, 8'h06, 8'h14, 8'h03, 8'h61, 8'h00, 8'h00});
    rollCheck("R5 11PM to 12AM next day", {8'h25, 8'h06, 8'h14, 8'h03, 8'h71, 8'h59, 8'h59},
                                          {8'h25, 8'h06, 8'h15, 8'h04, 8'h52, 8'h00, 8'h00});
    rollCheck("R5 12AM to 1AM", {8'h25, 8'h06, 8'h14, 8'h03, 8'h52, 8'h59, 8'h59},
                                {8'h25, 8'h06, 8'h14, 8'h03, 8'h41, 8'h00, 8'h00});
    rollCheck("R5 9AM to 10AM", {8'h25, 8'h06, 8'h14, 8'h03, 8'h49, 8'h59, 8'h59},
                                {8'h25, 8'h06, 8'h14, 8'h03, 8'h50, 8'h00, 8'h00});

    rollCheck("R9 weekday 7 to 1", {8'h25, 8'h06, 8'h14, 8'h07, 8'h23, 8'h59, 8'h59},
                                   {8'h25, 8'h06, 8'h15, 8'h01, 8'h00, 8'h00, 8'h00});

    rollCheck("R6 April 30 ends", {8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59},
                                  {8'h25, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R6 April 29 continues", {8'h25, 8'h04, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59},
                                       {8'h25, 8'h04, 8'h30, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R6 January 31 ends", {8'h25, 8'h01, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59},
                                    {8'h25, 8'h02, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00});
    rollCheck("R6 November 30 ends", {8'h25, 8'h11, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59},
                                     {8'h25, 8'h12, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00});

    rollCheck("R7 Feb 28 common year", {8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59},
                                       {8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R7 Feb 28 leap 24", {8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59},
                                   {8'h24, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R7 Feb 29 leap ends", {8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59},
                                     {8'h24, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R7 Feb 28 leap 00", {8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59},
                                   {8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R7 Feb 28 year 10", {8'h10, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59},
                                   {8'h10, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00});
    rollCheck("R7 Feb 28 leap 12", {8'h12, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59},
                                   {8'h12, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00});

    rollCheck("R8 year advance", {8'h25, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59},
                                 {8'h26, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00});
    rollCheck("R8 century wrap", {8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59},
                                 {8'h00, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00});

    setTime({8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h30});
    oscHalt = 1'b1;
    runTicks(2 * TICKS);
    expectNow("R10 halted clock frozen", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h30});
    runTicks(TICKS - 2);
    loadReg(3'd0, 8'h20, 1'b0);
    expectNow("R10 load while halted", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h20});
    oscHalt = 1'b0;
    runTicks(TICKS - 1);
    expectNow("R10 resume no early step", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h20});
    runTicks(1);
    expectNow("R10 resume steps", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h21});

    runTicks(2);
    oscHalt = 1'b1;
    runTicks(TICKS);
    oscHalt = 1'b0;
    runTicks(1);
    expectNow("R10 prescaler held through halt", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h21});
    runTicks(1);
    expectNow("R10 held count completes second", {8'h25, 8'h06, 8'h14, 8'h03, 8'h09, 8'h15, 8'h22});

    wait (expQ.size() == 0);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule